// File: doc/BRIEF.md
# Guest Supervisor Status Register

This block holds the 64-bit status word of a guest (virtualised) supervisor privilege level. Software reaches it through a simple CSR port: an address, write data and a write strobe. The read data is driven combinationally whenever the address matches the block's own CSR address. Besides software writes, the pipeline signals four hardware events: trap entry into guest supervisor mode, return from such a trap, a write to floating-point context, and a write to vector context. Each event updates the saved privilege and interrupt-enable state, or marks a context as dirty, without any software involvement.

The register keeps the writable fields and hardwires the fixed ones. It forms a dirty summary bit from its own context-status fields only. It also drives the enables that the rest of the core uses: floating-point and vector unit enables, per-source guest interrupt enables, and the privilege to return to. Writable fields clear to 0 on reset. Bits with no field always read 0.

Top module: `gstat_csr`

## Requirements
- R1: After reset, a read at the block's address returns 64'h0000_0001_0000_0000. All writable fields are 0 and bits 33:32 hold 1.
- R2: A software write at the block's address updates these fields from the write data: MXR bit 19, SUM bit 18, FS bits 14:13, VS bits 10:9, SPP bit 8, SPIE bit 5 and SIE bit 1. The new value reads back from the next cycle on. Bits 33:32 always read 1, and every other bit from 0 to 62 reads 0, whatever was written.
- R3: Bit 63 reads 1 exactly when FS or VS holds 3. Host-level FP state has no influence on it.
- R4: A floating-point context write event sets FS to 3. A vector context write event sets VS to 3.
- R5: A trap-entry event copies the prior-privilege input into SPP (1 = guest supervisor, 0 = guest user), copies the old SIE into SPIE, and clears SIE.
- R6: A return event copies SPIE into SIE, sets SPIE to 1 and clears SPP. The return-privilege output always shows the current SPP.
- R7: In a cycle with both a hardware event and a software write, any field the event touches takes the event's value, and the remaining written fields take the software data. Trap entry overrides a return event in the same cycle.
- R8: The FP enable output is 1 only when FS is nonzero and the host FP-on input is 1. The vector enable output is 1 only when VS is nonzero.
- R9: Each interrupt-enable output bit equals its mask input bit ANDed with (guest supervisor mode active AND SIE).
- R10: When the address does not match, a write has no effect on any field and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 64 | CSR write data |
| csrWe | input | 1 | CSR write strobe |
| csrRdata | output | 64 | CSR read data, 0 when address misses |
| trapEnter | input | 1 | Trap taken into guest supervisor mode |
| trapFromSup | input | 1 | Prior privilege at trap entry, 1 = guest supervisor |
| sretEvent | input | 1 | Return from guest supervisor trap |
| fpWrite | input | 1 | FP register or FP control/status written in guest mode |
| vecWrite | input | 1 | Vector register or vector CSR written |
| inGuestSup | input | 1 | Current privilege is guest supervisor |
| hostFpOn | input | 1 | Host-level FP status is nonzero |
| irqMask | input | 3 | Per-source guest interrupt enable mask |
| irqEnable | output | 3 | Effective per-source guest interrupt enable |
| fpEnable | output | 1 | FP instructions allowed |
| vecEnable | output | 1 | Vector instructions allowed |
| retToSup | output | 1 | Privilege a return goes to, 1 = guest supervisor |

## Verification
Software writes and hardware events are captured at one rising edge and are visible at the outputs from that edge onward. The read data and all enable outputs are combinational from the stored fields and the current inputs, with no further register in between. The bench drives each stimulus at a falling edge, lets one rising edge pass, updates its arithmetic model of the fields, and compares every output at the following falling edge while the same address and mode inputs are still applied. So each result is checked exactly one edge after its cause, and the combinational paths are checked against the same inputs.

// File: rtl/gstat_pkg.sv
package gstat_pkg;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 12;
  localparam int SD_POS   = 63;
  localparam int UXL_LO   = 32;
  localparam int MXR_POS  = 19;
  localparam int SUM_POS  = 18;
  localparam int FS_LO    = 13;
  localparam int VS_LO    = 9;
  localparam int SPP_POS  = 8;
  localparam int SPIE_POS = 5;
  localparam int SIE_POS  = 1;
  localparam logic [1:0] CTX_DIRTY = 2'd3;

  typedef struct packed {
    logic swWr;
    logic trap;
    logic sret;
    logic fpDirty;
    logic vecDirty;
  } gstatStb_t;
endpackage

// File: rtl/gstat_ctrl.sv
module gstat_ctrl
  import gstat_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  input  logic              trapEnter,
  input  logic              sretEvent,
  input  logic              fpWrite,
  input  logic              vecWrite,
  output logic              addrHit,
  output gstatStb_t         stb
);
  always_comb begin
    addrHit      = (csrAddr == CSR_ADDR);
    stb.swWr     = csrWe & addrHit;
    stb.trap     = trapEnter;
    stb.sret     = sretEvent & ~trapEnter;
    stb.fpDirty  = fpWrite;
    stb.vecDirty = vecWrite;
  end

  // trap and return never reach the datapath together
  assert_trap_over_sret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.trap, stb.sret}));
  assert_miss_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csrAddr != CSR_ADDR) |-> !stb.swWr);
endmodule

// File: rtl/gstat_dp.sv
module gstat_dp
  import gstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  gstatStb_t         stb,
  input  logic [DATA_W-1:0] wd,
  input  logic              trapFromSup,
  output logic [DATA_W-1:0] word,
  output logic [1:0]        fsQ,
  output logic [1:0]        vsQ,
  output logic              sieQ,
  output logic              sppQ
);
  logic mxrQ, sumQ, spieQ;
  logic mxrD, sumD, spieD, sieD, sppD;
  logic [1:0] fsD, vsD;

  wire unusedWd = ^{wd[63:20], wd[17:15], wd[12:11], wd[7:6], wd[4:2], wd[0]};

  always_comb begin
    mxrD  = stb.swWr ? wd[MXR_POS] : mxrQ;
    sumD  = stb.swWr ? wd[SUM_POS] : sumQ;
    fsD   = stb.fpDirty  ? CTX_DIRTY : (stb.swWr ? wd[FS_LO+:2] : fsQ);
    vsD   = stb.vecDirty ? CTX_DIRTY : (stb.swWr ? wd[VS_LO+:2] : vsQ);
    sieD  = sieQ;
    spieD = spieQ;
    sppD  = sppQ;
    if (stb.trap) begin
      sieD  = 1'b0;
      spieD = sieQ;
      sppD  = trapFromSup;
    end else if (stb.sret) begin
      sieD  = spieQ;
      spieD = 1'b1;
      sppD  = 1'b0;
    end else if (stb.swWr) begin
      sieD  = wd[SIE_POS];
      spieD = wd[SPIE_POS];
      sppD  = wd[SPP_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mxrQ <= 1'b0; sumQ <= 1'b0; fsQ <= 2'd0; vsQ <= 2'd0;
      sieQ <= 1'b0; spieQ <= 1'b0; sppQ <= 1'b0;
    end else begin
      mxrQ <= mxrD; sumQ <= sumD; fsQ <= fsD; vsQ <= vsD;
      sieQ <= sieD; spieQ <= spieD; sppQ <= sppD;
    end
  end

  always_comb begin
    word              = '0;
    word[SD_POS]      = (fsQ == CTX_DIRTY) | (vsQ == CTX_DIRTY);
    word[UXL_LO+:2]   = 2'd1;
    word[MXR_POS]     = mxrQ;
    word[SUM_POS]     = sumQ;
    word[FS_LO+:2]    = fsQ;
    word[VS_LO+:2]    = vsQ;
    word[SPP_POS]     = sppQ;
    word[SPIE_POS]    = spieQ;
    word[SIE_POS]     = sieQ;
  end

  assert_fp_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.fpDirty |=> (fsQ == CTX_DIRTY));
  assert_vec_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.vecDirty |=> (vsQ == CTX_DIRTY));
  assert_trap_clears_sie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.trap |=> !sieQ);
  assert_trap_saves_sie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.trap |=> (spieQ == $past(sieQ)));
  assert_sret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.sret |=> (spieQ && !sppQ && sieQ == $past(spieQ)));
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.swWr | stb.trap | stb.sret | stb.fpDirty | stb.vecDirty) |=> $stable(word));
endmodule

// File: rtl/gstat_csr.sv
module gstat_csr
  import gstat_pkg::*;
#(
  parameter logic [11:0] CSR_ADDR = 12'h200,
  parameter int          IRQ_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      csrAddr,
  input  logic [63:0]      csrWdata,
  input  logic             csrWe,
  output logic [63:0]      csrRdata,
  input  logic             trapEnter,
  input  logic             trapFromSup,
  input  logic             sretEvent,
  input  logic             fpWrite,
  input  logic             vecWrite,
  input  logic             inGuestSup,
  input  logic             hostFpOn,
  input  logic [IRQ_W-1:0] irqMask,
  output logic [IRQ_W-1:0] irqEnable,
  output logic             fpEnable,
  output logic             vecEnable,
  output logic             retToSup
);
  gstatStb_t         stb;
  logic              addrHit;
  logic [DATA_W-1:0] word;
  logic [1:0]        fsQ, vsQ;
  logic              sieQ, sppQ;

  gstat_ctrl #(.CSR_ADDR(CSR_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWe(csrWe),
    .trapEnter(trapEnter), .sretEvent(sretEvent), .fpWrite(fpWrite),
    .vecWrite(vecWrite), .addrHit(addrHit), .stb(stb)
  );

  gstat_dp dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wd(csrWdata), .trapFromSup(trapFromSup),
    .word(word), .fsQ(fsQ), .vsQ(vsQ), .sieQ(sieQ), .sppQ(sppQ)
  );

  assign csrRdata  = addrHit ? word : '0;
  assign fpEnable  = (fsQ != 2'd0) & hostFpOn;
  assign vecEnable = (vsQ != 2'd0);
  assign retToSup  = sppQ;
  assign irqEnable = irqMask & {IRQ_W{inGuestSup & sieQ}};

  assert_sd_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csrAddr == CSR_ADDR) |-> (csrRdata[63] ==
      ((csrRdata[14:13] == 2'd3) || (csrRdata[10:9] == 2'd3))));
  assert_uxl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csrAddr == CSR_ADDR) |-> (csrRdata[33:32] == 2'd1 && csrRdata[17:15] == 3'd0
      && csrRdata[6] == 1'b0));
  assert_fp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hostFpOn |-> !fpEnable);
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inGuestSup |-> (irqEnable == '0));
endmodule

// File: tb/gstat_csr_tb.sv
module gstat_csr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] ADDR = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csrAddr = ADDR;
  logic [63:0] csrWdata = '0;
  logic        csrWe = 1'b0;
  logic [63:0] csrRdata;
  logic        trapEnter = 1'b0, trapFromSup = 1'b0, sretEvent = 1'b0;
  logic        fpWrite = 1'b0, vecWrite = 1'b0, inGuestSup = 1'b0, hostFpOn = 1'b0;
  logic [2:0]  irqMask = '0;
  logic [2:0]  irqEnable;
  logic        fpEnable, vecEnable, retToSup;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic mMxr, mSum, mSpp, mSpie, mSie;
  logic [1:0] mFs, mVs;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  gstat_csr dut_i (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWdata(csrWdata), .csrWe(csrWe),
    .csrRdata(csrRdata), .trapEnter(trapEnter), .trapFromSup(trapFromSup),
    .sretEvent(sretEvent), .fpWrite(fpWrite), .vecWrite(vecWrite),
    .inGuestSup(inGuestSup), .hostFpOn(hostFpOn), .irqMask(irqMask),
    .irqEnable(irqEnable), .fpEnable(fpEnable), .vecEnable(vecEnable),
    .retToSup(retToSup)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expWord();
    logic [63:0] e = '0;
    e[63] = (mFs == 2'd3) || (mVs == 2'd3);
    e[33:32] = 2'd1;
    e[19] = mMxr; e[18] = mSum; e[14:13] = mFs; e[10:9] = mVs;
    e[8] = mSpp; e[5] = mSpie; e[1] = mSie;
    return e;
  endfunction

  task automatic checkAll();
    chk("R1/R2/R3/R10 rdata", csrRdata, (csrAddr == ADDR) ? expWord() : 64'd0);
    chk("R8 fpEnable", {63'd0, fpEnable}, {63'd0, (mFs != 0) && hostFpOn});
    chk("R8 vecEnable", {63'd0, vecEnable}, {63'd0, mVs != 0});
    chk("R9 irqEnable", {61'd0, irqEnable}, {61'd0, irqMask & {3{inGuestSup & mSie}}});
    chk("R6 retToSup", {63'd0, retToSup}, {63'd0, mSpp});
  endtask

  // model update, per the field rules and event priority (R4-R7)
  task automatic modelStep();
    logic hit = (csrAddr == ADDR);
    logic sw = csrWe && hit;
    logic oSie = mSie, oSpie = mSpie;
    if (sw) begin
      mMxr = csrWdata[19]; mSum = csrWdata[18];
      mFs = csrWdata[14:13]; mVs = csrWdata[10:9];
    end
    if (fpWrite) mFs = 2'd3;
    if (vecWrite) mVs = 2'd3;
    if (trapEnter) begin
      mSie = 1'b0; mSpie = oSie; mSpp = trapFromSup;
    end else if (sretEvent) begin
      mSie = oSpie; mSpie = 1'b1; mSpp = 1'b0;
    end else if (sw) begin
      mSie = csrWdata[1]; mSpie = csrWdata[5]; mSpp = csrWdata[8];
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  function automatic logic [63:0] nextRng(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
    return x;
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        misses++; vectors++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    mMxr = 0; mSum = 0; mSpp = 0; mSpie = 0; mSie = 0; mFs = 0; mVs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset value
    chk("R1 reset word", csrRdata, 64'h0000_0001_0000_0000);
    checkAll();

    // R3/R8: sweep every FS x VS pair with host FP both ways
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 4; v++) begin
        for (int h = 0; h < 2; h++) begin
          csrWe = 1'b1; csrAddr = ADDR; hostFpOn = h[0];
          csrWdata = 64'hFFFF_FFFF_FFFF_FFFF;
          csrWdata[14:13] = f[1:0]; csrWdata[10:9] = v[1:0];
          step();
        end
      end
    end

    // R5/R6: explicit trap then return sequence
    csrWe = 1'b1; csrWdata = 64'h2; step();          // SIE=1, rest 0
    csrWe = 1'b0; trapEnter = 1'b1; trapFromSup = 1'b1; step();
    chk("R5 trap SPIE<-SIE, SIE=0, SPP=1", csrRdata & 64'h122, 64'h120);
    trapEnter = 1'b0; sretEvent = 1'b1; step();
    chk("R6 sret SIE<-SPIE, SPIE=1, SPP=0", csrRdata & 64'h122, 64'h022);
    sretEvent = 1'b0;

    // R7/R10 and all: near-exhaustive sweep of event/write/address combinations
    for (int ev = 0; ev < 256; ev++) begin
      for (int p = 0; p < 4; p++) begin
        rng = nextRng(rng);
        csrWe       = ev[0];
        csrAddr     = ev[1] ? ADDR : (ADDR ^ 12'h001);
        trapEnter   = ev[2];
        sretEvent   = ev[3];
        fpWrite     = ev[4];
        vecWrite    = ev[5];
        trapFromSup = ev[6] ^ p[0];
        inGuestSup  = ev[7] | p[1];
        hostFpOn    = rng[40];
        irqMask     = rng[50:48];
        case (p)
          0: csrWdata = 64'hFFFF_FFFF_FFFF_FFFF;
          1: csrWdata = 64'd0;
          2: csrWdata = 64'hAAAA_AAAA_AAAA_AAAA ^ {64{ev[0]}};
          default: csrWdata = rng;
        endcase
        step();
      end
    end

    csrWe = 0; trapEnter = 0; sretEvent = 0; fpWrite = 0; vecWrite = 0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule